// File: doc/BRIEF.md
# Keccak Lane Operation Unit

This unit executes the lane-level steps of the Keccak-f[1600] permutation as single custom instructions on a 64-bit processor. Beside the general-purpose registers it keeps a private file of 64-bit lanes that is large enough to hold the whole 5x5 state. Some instructions take their operands from that file: a column parity over five consecutive lanes, and the chi-step AND-NOT-XOR over three lanes. Others combine two GPR operands: rotate by one then XOR, and XOR then rotate by an immediate. Two move instructions copy a lane into a GPR and a GPR into a lane.

The surrounding pipeline presents one decoded instruction per cycle on `issue`. It supplies a 3-bit operation code, the register index fields, the 7-bit immediate and the two GPR source values. The result and the GPR write strobe appear in the cycle after issue. A lane write lands on the issuing clock edge, so the next instruction already reads the new lane. A small state machine tracks what the previous cycle issued. In `ST_IDLE`, nothing is pending. In `ST_GPR`, a result is due for the GPR file. In `ST_LANE`, the last instruction wrote a lane. At every edge the machine moves to `ST_GPR` on a GPR-writing issue, to `ST_LANE` on a lane write, and to `ST_IDLE` otherwise.

Top module: `kl_unit`

## Requirements
- R1: After reset, `gpr_we` is 0, `res` is 0 and every lane of the file reads as 0.
- R2: Operation code 0 (column parity) returns the XOR of the lanes at indices b, b+1, b+2, b+3 and b+4, where b is `rs1` and each index is taken modulo the lane count (25).
- R3: Operation code 1 returns `gpr_a` rotated left by one bit, XORed with `gpr_b`.
- R4: Operation code 2 returns lane[`rs1`] XOR ((NOT lane[`rs2`]) AND lane[`rs3`]).
- R5: Operation code 3 returns (`gpr_a` XOR `gpr_b`) rotated left by `imm[5:0]`. Bit 6 of `imm` is ignored, and an amount of 0 returns the plain XOR.
- R6: Operation code 4 returns lane[`rs1`]. Operation code 5 stores `gpr_a` into lane[`rd`] and raises no GPR write.
- R7: For codes 0 to 4, `res` holds the result and `gpr_we` is 1 in the cycle after issue. `gpr_we` is 0 in the cycle after a cycle with no issue, a code-5 issue, or an issue of the unused codes 6 and 7.
- R8: A lane write takes effect at the issuing edge. An instruction issued in the very next cycle reads the new value.
- R9: Every lane index at or above the lane count selects lane (index modulo 25), for both reads and writes. Unused codes 6 and 7 leave every lane unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction is presented this cycle |
| op | input | 3 | Operation code (0 parity, 1 rot1-xor, 2 chi, 3 xor-rot, 4 lane-to-GPR, 5 GPR-to-lane) |
| rs1 | input | 5 | First source index |
| rs2 | input | 5 | Second source index |
| rs3 | input | 5 | Third source index (chi form) |
| rd | input | 5 | Destination lane index for the GPR-to-lane move |
| imm | input | 7 | Rotate amount field |
| gpr_a | input | 64 | Value of GPR rs1 |
| gpr_b | input | 64 | Value of GPR rs2 |
| res | output | 64 | Result for GPR rd |
| gpr_we | output | 1 | GPR write strobe |

## Verification
A GPR-to-lane move and a read of the same lane can meet: the write lands on the same edge that starts the reading instruction's cycle. The bench provokes this by issuing a lane write immediately followed by a lane read, parity or chi step that names the same lane, with no idle cycle between them. Random streams do the same by drawing indices from a narrow window. Each result is judged against a bench-side lane model that applies the write before evaluating the next instruction, so a stale read shows up as a miscompare.

// File: rtl/kl_pkg.sv
package kl_pkg;
    typedef enum logic [2:0] {
        OP_COLX  = 3'd0,
        OP_ROT1X = 3'd1,
        OP_CHI   = 3'd2,
        OP_XROT  = 3'd3,
        OP_LRD   = 3'd4,
        OP_LWR   = 3'd5
    } kl_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GPR  = 2'd1,
        ST_LANE = 2'd2
    } kl_state_e;

    localparam int COL_N = 5;
endpackage

// File: rtl/kl_lane_file.sv
module kl_lane_file #(
    parameter int LANE_W = 64,
    parameter int NLANES = 25,
    parameter int IDXW   = 5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [IDXW-1:0]                       wr_idx,
    input  logic [LANE_W-1:0]                     wr_data,
    input  logic [2:0][IDXW-1:0]                  rd_idx,
    output logic [2:0][LANE_W-1:0]                rd_val,
    output logic [kl_pkg::COL_N-1:0][LANE_W-1:0]  col_val
);
    localparam int AW = $clog2(NLANES);

    logic [LANE_W-1:0] lanes [NLANES];

    function automatic logic [AW-1:0] wrap(input int i);
        return AW'(i % NLANES);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLANES; i++) lanes[i] <= '0;
        end else if (wr_en) begin
            lanes[wrap(int'(wr_idx))] <= wr_data;
        end
    end

    for (genvar p = 0; p < 3; p++) begin : g_rd
        assign rd_val[p] = lanes[wrap(int'(rd_idx[p]))];
    end

    for (genvar k = 0; k < kl_pkg::COL_N; k++) begin : g_col
        assign col_val[k] = lanes[wrap(int'(rd_idx[0]) + k)];
    end
endmodule

// File: rtl/kl_alu.sv
module kl_alu #(
    parameter int LANE_W = 64,
    parameter int IMMW   = 7
) (
    input  logic [2:0]                            op,
    input  logic [IMMW-1:0]                       imm,
    input  logic [LANE_W-1:0]                     a,
    input  logic [LANE_W-1:0]                     b,
    input  logic [2:0][LANE_W-1:0]                cr,
    input  logic [kl_pkg::COL_N-1:0][LANE_W-1:0]  col,
    output logic [LANE_W-1:0]                     y
);
    import kl_pkg::*;
    localparam int SHW = $clog2(LANE_W);

    function automatic logic [LANE_W-1:0] rotl(input logic [LANE_W-1:0] x, input int s);
        return (s == 0) ? x : ((x << s) | (x >> (LANE_W - s)));
    endfunction

    logic [LANE_W-1:0] parity;

    always_comb begin
        parity = '0;
        for (int k = 0; k < COL_N; k++) parity = parity ^ col[k];
    end

    always_comb begin
        unique case (op)
            OP_COLX:  y = parity;
            OP_ROT1X: y = rotl(a, 1) ^ b;
            OP_CHI:   y = cr[0] ^ (~cr[1] & cr[2]);
            OP_XROT:  y = rotl(a ^ b, int'(imm[SHW-1:0]));
            OP_LRD:   y = cr[0];
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/kl_unit.sv
module kl_unit #(
    parameter int LANE_W = 64,
    parameter int NLANES = 25,
    parameter int IDXW   = 5,
    parameter int IMMW   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [2:0]        op,
    input  logic [IDXW-1:0]   rs1,
    input  logic [IDXW-1:0]   rs2,
    input  logic [IDXW-1:0]   rs3,
    input  logic [IDXW-1:0]   rd,
    input  logic [IMMW-1:0]   imm,
    input  logic [LANE_W-1:0] gpr_a,
    input  logic [LANE_W-1:0] gpr_b,
    output logic [LANE_W-1:0] res,
    output logic              gpr_we
);
    import kl_pkg::*;

    kl_state_e state_q, state_d;
    logic [LANE_W-1:0] res_q;
    logic [LANE_W-1:0] alu_y;
    logic [2:0][IDXW-1:0] rd_idx;
    logic [2:0][LANE_W-1:0] cr_val;
    logic [COL_N-1:0][LANE_W-1:0] col_val;
    logic lane_wr, gpr_op;

    assign lane_wr = issue && (op == OP_LWR);
    assign gpr_op  = issue && (op <= OP_LRD);
    assign rd_idx  = {rs3, rs2, rs1};

    kl_lane_file #(.LANE_W(LANE_W), .NLANES(NLANES), .IDXW(IDXW)) u_file (
        .clk(clk), .rst_n(rst_n), .wr_en(lane_wr), .wr_idx(rd), .wr_data(gpr_a),
        .rd_idx(rd_idx), .rd_val(cr_val), .col_val(col_val)
    );

    kl_alu #(.LANE_W(LANE_W), .IMMW(IMMW)) u_alu (
        .op(op), .imm(imm), .a(gpr_a), .b(gpr_b), .cr(cr_val), .col(col_val), .y(alu_y)
    );

    // next-state selection
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_GPR, ST_LANE: begin
                if (gpr_op)       state_d = ST_GPR;
                else if (lane_wr) state_d = ST_LANE;
                else              state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            if (gpr_op) res_q <= alu_y;
        end
    end

    // outputs
    always_comb begin
        res = res_q;
        unique case (state_q)
            ST_GPR:  gpr_we = 1'b1;
            default: gpr_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/kl_unit_chk.sv
module kl_unit_chk #(
    parameter int LANE_W = 64,
    parameter int IMMW   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic [2:0]        op,
    input logic [IMMW-1:0]   imm,
    input logic [LANE_W-1:0] gpr_a,
    input logic [LANE_W-1:0] gpr_b,
    input logic [LANE_W-1:0] res,
    input logic              gpr_we
);
    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n) !issue |=> !gpr_we); // R7
    AST_LWR_NO_WE: assert property (@(posedge clk) disable iff (!rst_n) (issue && op == 3'd5) |=> !gpr_we); // R6
    AST_GPR_OP_WE: assert property (@(posedge clk) disable iff (!rst_n) (issue && op <= 3'd4) |=> gpr_we); // R7
    AST_ROT1X_RES: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == 3'd1) |=> res == ({$past(gpr_a[LANE_W-2:0]), $past(gpr_a[LANE_W-1])} ^ $past(gpr_b))); // R3
    AST_XROT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == 3'd3 && imm[5:0] == 6'd0) |=> res == ($past(gpr_a) ^ $past(gpr_b))); // R5
endmodule

bind kl_unit kl_unit_chk #(.LANE_W(LANE_W), .IMMW(IMMW)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .imm(imm),
    .gpr_a(gpr_a), .gpr_b(gpr_b), .res(res), .gpr_we(gpr_we)
);

// File: tb/kl_unit_tb.sv
module kl_unit_tb;
    localparam int N = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue = 1'b0;
    logic [2:0] op = '0;
    logic [4:0] rs1 = '0, rs2 = '0, rs3 = '0, rd = '0;
    logic [6:0] imm = '0;
    logic [63:0] gpr_a = '0, gpr_b = '0;
    logic [63:0] res;
    logic gpr_we;

    logic [63:0] model [N];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    kl_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .rs1(rs1), .rs2(rs2),
        .rs3(rs3), .rd(rd), .imm(imm), .gpr_a(gpr_a), .gpr_b(gpr_b),
        .res(res), .gpr_we(gpr_we)
    );

    function automatic logic [63:0] brot(input logic [63:0] x, input int s);
        return (s == 0) ? x : ((x << s) | (x >> (64 - s)));
    endfunction

    function automatic logic [63:0] lane(input int i);
        return model[i % N];
    endfunction

    function automatic logic [63:0] expect_res(input logic [2:0] o, input int r1, input int r2,
                                               input int r3, input logic [6:0] im,
                                               input logic [63:0] a, input logic [63:0] b);
        logic [63:0] v;
        case (o)
            3'd0: begin
                v = '0;
                for (int k = 0; k < 5; k++) v = v ^ lane(r1 + k);
            end
            3'd1: v = brot(a, 1) ^ b;
            3'd2: v = lane(r1) ^ (~lane(r2) & lane(r3));
            3'd3: v = brot(a ^ b, int'(im[5:0]));
            3'd4: v = lane(r1);
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one instruction per cycle; outputs checked at the following negedge
    task automatic run(input string tag, input logic [2:0] o, input int r1, input int r2,
                       input int r3, input int d, input logic [6:0] im,
                       input logic [63:0] a, input logic [63:0] b);
        logic [63:0] e;
        e = expect_res(o, r1, r2, r3, im, a, b);
        issue = 1'b1; op = o; rs1 = 5'(r1); rs2 = 5'(r2); rs3 = 5'(r3); rd = 5'(d);
        imm = im; gpr_a = a; gpr_b = b;
        @(negedge clk);
        if (o <= 3'd4) begin
            check({tag, " we"}, {63'd0, gpr_we}, 64'd1);
            check({tag, " res"}, res, e);
        end else begin
            check({tag, " we"}, {63'd0, gpr_we}, 64'd0);
        end
        if (o == 3'd5) model[d % N] = a;
    endtask

    task automatic idle();
        issue = 1'b0;
        @(negedge clk);
        check("R7 idle we", {63'd0, gpr_we}, 64'd0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset we", {63'd0, gpr_we}, 64'd0);
        check("R1 reset res", res, 64'd0);
        run("R1 lane0 zero", 3'd4, 0, 0, 0, 0, 7'd0, 0, 0);
        run("R1 column zero", 3'd0, 20, 0, 0, 0, 7'd0, 0, 0);

        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < N; i++)
            run("R6 fill", 3'd5, 0, 0, 0, i, 7'd0, {$urandom, $urandom}, 0);
        idle();

        // directed corners
        run("R2 wrap col 22", 3'd0, 22, 0, 0, 0, 7'd0, 0, 0);
        run("R9 col idx 31", 3'd0, 31, 0, 0, 0, 7'd0, 0, 0);
        run("R5 rot zero", 3'd3, 0, 0, 0, 0, 7'd0, 64'h0123_4567_89ab_cdef, 64'hf0f0_0000_ffff_1111);
        run("R5 bit6 ignored", 3'd3, 0, 0, 0, 0, 7'd69, 64'h8000_0000_0000_0001, 64'd0);
        run("R5 rot 63", 3'd3, 0, 0, 0, 0, 7'd63, 64'h1, 64'h0);
        run("R3 msb wraps", 3'd1, 0, 0, 0, 0, 7'd0, 64'h8000_0000_0000_0000, 64'h2);
        run("R8 write lane 7", 3'd5, 0, 0, 0, 7, 7'd0, 64'hdead_beef_cafe_f00d, 0);
        run("R8 read lane 7", 3'd4, 7, 0, 0, 0, 7'd0, 0, 0);
        run("R8 write lane 3", 3'd5, 0, 0, 0, 3, 7'd0, 64'h1111_2222_3333_4444, 0);
        run("R8 col after write", 3'd0, 3, 0, 0, 0, 7'd0, 0, 0);
        run("R9 write idx 27", 3'd5, 0, 0, 0, 27, 7'd0, 64'h5a5a_5a5a_a5a5_a5a5, 0);
        run("R9 read lane 2", 3'd4, 2, 0, 0, 0, 7'd0, 0, 0);
        run("R4 chi", 3'd2, 2, 7, 3, 0, 7'd0, 0, 0);
        run("R9 unused op 6", 3'd6, 0, 0, 0, 4, 7'd0, 64'hffff_ffff_ffff_ffff, 0);
        run("R9 lane 4 intact", 3'd4, 4, 0, 0, 0, 7'd0, 0, 0);
        run("R7 unused op 7", 3'd7, 0, 0, 0, 4, 7'd0, 64'hffff, 0);
        run("R9 lane 4 still", 3'd4, 29, 0, 0, 0, 7'd0, 0, 0);
        idle();

        // constrained random stream, narrow index window to force write/read overlap
        for (int i = 0; i < 600; i++) begin
            logic [2:0] o;
            int base;
            o = 3'($urandom_range(0, 7));
            base = $urandom_range(0, 3) * 8;
            if ($urandom_range(0, 9) == 0) idle();
            run("R2-7 random", o, base + $urandom_range(0, 7), base + $urandom_range(0, 7),
                $urandom_range(0, 31), base + $urandom_range(0, 7), 7'($urandom),
                {$urandom, $urandom}, {$urandom, $urandom});
        end
        idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule